// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block is a hardware master for a small three-wire serial EEPROM that holds 128 bytes and uses a 7-bit address. A host hands it one operation at a time over a request/ready handshake. Each request carries a read/write select, an address and a data byte. The block drives chip select, the serial clock and the serial data line on its own. It samples the memory's serial output, and it raises a one-cycle done pulse when the operation is over. On a read, that pulse comes with the byte read. On a write, it comes with a timeout flag.

A read takes one chip-select period. The block sends a 10-bit command and then clocks in eight data bits. A write takes four chip-select periods, issued back to back with no host involvement:
1. It unlocks writes.
2. It sends the command with the data byte.
3. It polls the ready/busy status.
4. It locks writes again.

The status poll has a cycle limit, so a memory that never reports ready cannot hang the host. All serial timing is counted in system clock cycles and set by parameters.

Top module: `uwire_ee_master`

## Requirements
- R1: A read request produces exactly one chip-select period. In it the block shifts out the opcode bits 1,1,0 and then the 7-bit address, most significant bit first. It then gives eight more clock pulses and assembles the bits sampled on them, first bit as bit 7, into `rdata_o`, which is valid while `done_o` is high.
- R2: A write request produces exactly four chip-select periods, in this order:
  - the 10-bit word 0x260 (unlock);
  - an 18-bit frame made of the opcode bits 1,0,1, the 7-bit address and the 8 data bits, all most significant bit first;
  - a status poll;
  - the 10-bit word 0x200 (lock).
- R3: The status poll raises chip select and gives clock pulses. `sdi_i` is sampled at the end of each full pulse, after its low phase. The poll ends as soon as a sampled bit is 1, and chip select then drops.
- R4: If `POLL_LIMIT` pulses pass without a 1, the poll ends, `timeout_o` is set, and the lock word is still sent before `done_o`. A poll that sees 1 on pulse `POLL_LIMIT` is not a timeout.
- R5: Each clock pulse is high for exactly `HIGH_CYC` cycles and then low for at least `LOW_CYC` cycles. `sdo_o` changes only while `sclk_o` is low, and it is stable for at least `SETUP_CYC` cycles before each rising edge.
- R6: `sclk_o` is high only while `cs_o` is high, and `cs_o` changes only while `sclk_o` is low. The first rising clock edge comes at least `CS_SETUP_CYC + SETUP_CYC` cycles after chip select rises. Between two chip-select periods, `cs_o` stays low for at least `CS_GAP_CYC` cycles.
- R7: A request is taken when `req_i` and `ready_o` are both high. After that, `busy_o` is high and `ready_o` is low until the cycle of `done_o`, and requests made in that time are ignored and give no done pulse.
- R8: `done_o` is a single-cycle pulse, one per accepted request. `timeout_o` is cleared when a request is taken and keeps its value until the next one is taken.
- R9: After reset, `cs_o`, `sclk_o`, `sdo_o`, `done_o`, `busy_o` and `timeout_o` are low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| ready_o | output | 1 | Idle, a request is taken this cycle |
| wr_i | input | 1 | 1 = byte write sequence, 0 = byte read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Byte read, valid with done_o after a read |
| timeout_o | output | 1 | Status poll hit its limit |
| cs_o | output | 1 | Chip select to the memory, active high |
| sclk_o | output | 1 | Serial clock to the memory |
| sdo_o | output | 1 | Serial data to the memory |
| sdi_i | input | 1 | Serial data from the memory |

## Verification
The bound checker watches the pin-level rules on every cycle:
- the exact high width of each clock pulse;
- data-out held still while the clock is high;
- the clock confined to chip-select periods, and chip select moving only with the clock low;
- the minimum chip-select low gap;
- the handshake, the done pulse and how the timeout flag behaves.

Other behaviour shows only in the bench's scenarios, which run against a behavioural memory model:
- the content of each frame and the order of the four write transactions;
- the number of poll pulses for several busy lengths, including exactly at the limit and one past it;
- the data returned by reads;
- that a request made mid-operation is ignored.

// File: rtl/uwire_ee_pkg.sv
package uwire_ee_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_CSUP, SQ_TX, SQ_RX, SQ_POLL, SQ_GAP} seq_st_e;
  typedef enum logic [2:0] {PH_RD, PH_WEN, PH_WR, PH_POLL, PH_WDS} phase_e;
  typedef enum logic [1:0] {BT_IDLE, BT_SETUP, BT_HIGH, BT_LOW} bit_st_e;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [2:0] OPC_CTRL  = 3'b100;
  localparam logic [1:0] CTRL_WEN  = 2'b11;
  localparam logic [1:0] CTRL_WDS  = 2'b00;

  // bits needed for a down-counter holding 0..v-1
  function automatic int unsigned cnt_w(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/uwire_bit_timer.sv
module uwire_bit_timer
  import uwire_ee_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 25,
  parameter int unsigned HIGH_CYC  = 63,
  parameter int unsigned LOW_CYC   = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  input  logic sdi_i,
  output logic sclk_o,
  output logic sdo_o,
  output logic done_o,
  output logic rx_bit_o
);
  localparam int unsigned MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int unsigned MAX_C = (MAX_A > LOW_CYC) ? MAX_A : LOW_CYC;
  localparam int unsigned TW    = cnt_w(MAX_C);

  bit_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic          sclk_q, sdo_q, done_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BT_IDLE;
      tmr_q  <= '0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        BT_IDLE: if (start_i) begin
          sdo_q <= bit_i;
          tmr_q <= TW'(SETUP_CYC - 1);
          st_q  <= BT_SETUP;
        end
        BT_SETUP: if (tmr_q == '0) begin
          sclk_q <= 1'b1;
          tmr_q  <= TW'(HIGH_CYC - 1);
          st_q   <= BT_HIGH;
        end else tmr_q <= tmr_q - 1'b1;
        BT_HIGH: if (tmr_q == '0) begin
          sclk_q <= 1'b0;
          tmr_q  <= TW'(LOW_CYC - 1);
          st_q   <= BT_LOW;
        end else tmr_q <= tmr_q - 1'b1;
        BT_LOW: if (tmr_q == '0) begin
          rx_q   <= sdi_i;  // sampled once the full pulse is over
          done_q <= 1'b1;
          st_q   <= BT_IDLE;
        end else tmr_q <= tmr_q - 1'b1;
        default: st_q <= BT_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign sdo_o    = sdo_q;
  assign done_o   = done_q;
  assign rx_bit_o = rx_q;
endmodule

// File: rtl/uwire_ee_seq.sv
module uwire_ee_seq
  import uwire_ee_pkg::*;
#(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CS_SETUP_CYC = 13,
  parameter int unsigned CS_GAP_CYC   = 63,
  parameter int unsigned POLL_LIMIT   = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o,
  output logic              cs_o,
  output logic              bit_start_o,
  output logic              bit_val_o,
  input  logic              bit_done_i,
  input  logic              rx_bit_i
);
  localparam int unsigned CMD_W = 3 + ADDR_W;
  localparam int unsigned TX_W  = CMD_W + DATA_W;
  localparam int unsigned TXC_W = $clog2(TX_W + 1);
  localparam int unsigned RXC_W = $clog2(DATA_W + 1);
  localparam int unsigned PC_W  = cnt_w(POLL_LIMIT);
  localparam int unsigned TMR_M = (CS_SETUP_CYC > CS_GAP_CYC) ? CS_SETUP_CYC : CS_GAP_CYC;
  localparam int unsigned TMR_W = cnt_w(TMR_M);

  function automatic logic [TX_W-1:0] frame_of(phase_e ph, logic [ADDR_W-1:0] a,
                                              logic [DATA_W-1:0] d);
    unique case (ph)
      PH_RD:   return {OPC_READ, a, {DATA_W{1'b0}}};
      PH_WEN:  return {OPC_CTRL, CTRL_WEN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
      PH_WR:   return {OPC_WRITE, a, d};
      PH_WDS:  return {OPC_CTRL, CTRL_WDS, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [TXC_W-1:0] len_of(phase_e ph);
    unique case (ph)
      PH_WR:   return TXC_W'(TX_W);
      PH_POLL: return '0;
      default: return TXC_W'(CMD_W);
    endcase
  endfunction

  seq_st_e           st_q;
  phase_e            ph_q, launch_ph;
  logic [TX_W-1:0]   tx_sr_q;
  logic [TXC_W-1:0]  tx_left_q;
  logic [RXC_W-1:0]  rx_left_q;
  logic [DATA_W-1:0] rx_sr_q, rdata_q, data_q, launch_d;
  logic [ADDR_W-1:0] addr_q, launch_a;
  logic [PC_W-1:0]   poll_cnt_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              pend_q, cs_q, done_q, timeout_q, launch, finish;

  always_comb begin
    launch    = 1'b0;
    finish    = 1'b0;
    launch_ph = PH_RD;
    if (st_q == SQ_IDLE && req_i) begin
      launch    = 1'b1;
      launch_ph = wr_i ? PH_WEN : PH_RD;
    end else if (st_q == SQ_GAP && tmr_q == '0) begin
      unique case (ph_q)
        PH_WEN:  begin launch = 1'b1; launch_ph = PH_WR;   end
        PH_WR:   begin launch = 1'b1; launch_ph = PH_POLL; end
        PH_POLL: begin launch = 1'b1; launch_ph = PH_WDS;  end
        default: finish = 1'b1;
      endcase
    end
    launch_a = (st_q == SQ_IDLE) ? addr_i  : addr_q;
    launch_d = (st_q == SQ_IDLE) ? wdata_i : data_q;
  end

  assign bit_start_o = !pend_q && (st_q inside {SQ_TX, SQ_RX, SQ_POLL});
  assign bit_val_o   = (st_q == SQ_TX) && tx_sr_q[TX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      ph_q       <= PH_RD;
      tx_sr_q    <= '0;
      tx_left_q  <= '0;
      rx_left_q  <= '0;
      rx_sr_q    <= '0;
      rdata_q    <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      poll_cnt_q <= '0;
      tmr_q      <= '0;
      pend_q     <= 1'b0;
      cs_q       <= 1'b0;
      done_q     <= 1'b0;
      timeout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        if (st_q == SQ_IDLE) begin
          addr_q    <= addr_i;
          data_q    <= wdata_i;
          timeout_q <= 1'b0;
        end
        ph_q       <= launch_ph;
        tx_sr_q    <= frame_of(launch_ph, launch_a, launch_d);
        tx_left_q  <= len_of(launch_ph);
        rx_left_q  <= RXC_W'(DATA_W);
        poll_cnt_q <= '0;
        pend_q     <= 1'b0;
        cs_q       <= 1'b1;
        tmr_q      <= TMR_W'(CS_SETUP_CYC - 1);
        st_q       <= SQ_CSUP;
      end else if (finish) begin
        done_q <= 1'b1;
        st_q   <= SQ_IDLE;
      end else begin
        if (bit_start_o) begin
          pend_q <= 1'b1;
          if (st_q == SQ_TX) begin
            tx_sr_q   <= tx_sr_q << 1;
            tx_left_q <= tx_left_q - 1'b1;
          end
        end
        unique case (st_q)
          SQ_CSUP:
            if (tmr_q == '0) st_q <= (ph_q == PH_POLL) ? SQ_POLL : SQ_TX;
            else tmr_q <= tmr_q - 1'b1;
          SQ_TX: if (pend_q && bit_done_i) begin
            pend_q <= 1'b0;
            if (tx_left_q == '0) begin
              if (ph_q == PH_RD) st_q <= SQ_RX;
              else begin
                cs_q <= 1'b0; tmr_q <= TMR_W'(CS_GAP_CYC - 1); st_q <= SQ_GAP;
              end
            end
          end
          SQ_RX: if (pend_q && bit_done_i) begin
            pend_q    <= 1'b0;
            rx_sr_q   <= {rx_sr_q[DATA_W-2:0], rx_bit_i};
            rx_left_q <= rx_left_q - 1'b1;
            if (rx_left_q == RXC_W'(1)) begin
              rdata_q <= {rx_sr_q[DATA_W-2:0], rx_bit_i};
              cs_q <= 1'b0; tmr_q <= TMR_W'(CS_GAP_CYC - 1); st_q <= SQ_GAP;
            end
          end
          SQ_POLL: if (pend_q && bit_done_i) begin
            pend_q <= 1'b0;
            if (rx_bit_i || poll_cnt_q == PC_W'(POLL_LIMIT - 1)) begin
              if (!rx_bit_i) timeout_q <= 1'b1;
              cs_q <= 1'b0; tmr_q <= TMR_W'(CS_GAP_CYC - 1); st_q <= SQ_GAP;
            end else poll_cnt_q <= poll_cnt_q + 1'b1;
          end
          SQ_GAP: tmr_q <= tmr_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign ready_o   = (st_q == SQ_IDLE);
  assign busy_o    = (st_q != SQ_IDLE);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign timeout_o = timeout_q;
  assign cs_o      = cs_q;
endmodule

// File: rtl/uwire_ee_master.sv
module uwire_ee_master
  import uwire_ee_pkg::*;
#(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SETUP_CYC    = 25,
  parameter int unsigned HIGH_CYC     = 63,
  parameter int unsigned LOW_CYC      = 63,
  parameter int unsigned CS_SETUP_CYC = 13,
  parameter int unsigned CS_GAP_CYC   = 63,
  parameter int unsigned POLL_LIMIT   = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic bit_start, bit_val, bit_done, rx_bit;

  uwire_ee_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_SETUP_CYC(CS_SETUP_CYC),
    .CS_GAP_CYC(CS_GAP_CYC), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .timeout_o(timeout_o), .cs_o(cs_o),
    .bit_start_o(bit_start), .bit_val_o(bit_val), .bit_done_i(bit_done),
    .rx_bit_i(rx_bit)
  );

  uwire_bit_timer #(
    .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)
  ) u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(bit_start), .bit_i(bit_val),
    .sdi_i(sdi_i), .sclk_o(sclk_o), .sdo_o(sdo_o), .done_o(bit_done),
    .rx_bit_o(rx_bit)
  );
endmodule

// File: rtl/uwire_ee_master_chk.sv
module uwire_ee_master_chk #(
  parameter int unsigned HIGH_CYC   = 63,
  parameter int unsigned CS_GAP_CYC = 63
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ready_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic cs_o,
  input logic sclk_o,
  input logic sdo_o
);
  logic [31:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= 32'(CS_GAP_CYC);
    end else begin
      hi_cnt <= sclk_o ? hi_cnt + 1 : '0;
      if (cs_o) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1;
    end
  end

  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_cnt == 32'(HIGH_CYC)); // R5
  AST_SDO_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o)); // R5
  AST_SCLK_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> cs_o); // R6
  AST_CS_MOVE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) || $fell(cs_o)) |-> !sclk_o && !$past(sclk_o)); // R6
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> lo_cnt >= 32'(CS_GAP_CYC)); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> busy_o && !ready_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !cs_o); // R8
  AST_TIMEOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !(ready_o && req_i) |=> timeout_o); // R8
  AST_TIMEOUT_IN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> busy_o && !cs_o); // R4
endmodule

bind uwire_ee_master uwire_ee_master_chk #(
  .HIGH_CYC(HIGH_CYC), .CS_GAP_CYC(CS_GAP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
  .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .cs_o(cs_o),
  .sclk_o(sclk_o), .sdo_o(sdo_o)
);

// File: tb/uwire_ee_master_tb.sv
`timescale 1ns/1ps
module uwire_ee_master_tb;
  localparam int SETUP = 3, HIGH = 4, LOW = 4, CSU = 2, GAP = 5, LIMIT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, sdi = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, busy, done, timeout, cs, sclk, sdo;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  uwire_ee_master #(
    .SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .LOW_CYC(LOW),
    .CS_SETUP_CYC(CSU), .CS_GAP_CYC(GAP), .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .timeout_o(timeout), .cs_o(cs), .sclk_o(sclk),
    .sdo_o(sdo), .sdi_i(sdi)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  typedef enum {MD_CMD, MD_STAT, MD_READ, MD_WDATA} md_e;
  md_e         m_mode = MD_CMD;
  logic [7:0]  m_mem [128];
  logic [7:0]  shadow [128];
  logic [17:0] m_sh = '0;
  logic [9:0]  m_cmdw = '0;
  logic [6:0]  m_ra = '0;
  int          m_nbits = 0, m_rk = 0, m_busy = 0, busy_cfg = 0, log_idx = 0;
  bit          m_wen = 0, m_stat_pend = 0, m_cs_q = 0, m_sclk_q = 0;
  logic [9:0]  m_logw [8];
  int          m_logb [8];

  always @(negedge clk) begin
    if (cs && !m_cs_q) begin
      m_nbits = 0; m_sh = '0; m_cmdw = '0;
      m_mode = m_stat_pend ? MD_STAT : MD_CMD;
      m_stat_pend = 0;
    end
    if (cs && sclk && !m_sclk_q) begin
      m_nbits++;
      case (m_mode)
        MD_STAT: begin
          if (m_busy > 0) m_busy--;
          sdi = (m_busy == 0);
        end
        MD_CMD: begin
          m_sh = {m_sh[16:0], sdo};
          if (m_nbits == 10) begin
            m_cmdw = m_sh[9:0];
            case (m_sh[9:7])
              3'b110: begin m_mode = MD_READ; m_ra = m_sh[6:0]; m_rk = 0; end
              3'b101: m_mode = MD_WDATA;
              3'b100: if (m_sh[6:5] == 2'b11) m_wen = 1;
                      else if (m_sh[6:5] == 2'b00) m_wen = 0;
              default: ;
            endcase
          end
        end
        MD_READ: begin
          sdi = (m_rk < 8) ? m_mem[m_ra][7-m_rk] : 1'b0;
          m_rk++;
        end
        MD_WDATA: begin
          m_sh = {m_sh[16:0], sdo};
          if (m_nbits == 18) begin
            if (m_wen) m_mem[m_sh[14:8]] = m_sh[7:0];
            m_stat_pend = 1;
            m_busy = busy_cfg;
          end
        end
        default: ;
      endcase
    end
    if (!cs && m_cs_q) begin
      if (log_idx < 8) begin m_logw[log_idx] = m_cmdw; m_logb[log_idx] = m_nbits; end
      log_idx++;
      sdi = 1'b0;
    end
    m_cs_q = cs; m_sclk_q = sclk;
  end

  // ---------------- pin timing measurement ----------------
  int hi_run = 0, hi_min = 1000, hi_max = 0;
  int sdo_age = 1000, setup_min = 1000, cs_age = 0, csfirst_min = 1000;
  bit t_sclk_q = 0, t_sdo_q = 0, t_cs_q = 0, first_pending = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sdo != t_sdo_q) sdo_age = 0; else sdo_age++;
      if (cs && !t_cs_q) begin cs_age = 0; first_pending = 1; end else cs_age++;
      if (sclk) begin
        if (!t_sclk_q) begin
          if (sdo_age < setup_min) setup_min = sdo_age;
          if (first_pending && cs_age < csfirst_min) csfirst_min = cs_age;
          first_pending = 0;
        end
        hi_run++;
      end else begin
        if (t_sclk_q) begin
          if (hi_run < hi_min) hi_min = hi_run;
          if (hi_run > hi_max) hi_max = hi_run;
        end
        hi_run = 0;
      end
      t_sclk_q = sclk; t_sdo_q = sdo; t_cs_q = cs;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit       wr;
    bit [6:0] a;
    bit [7:0] d;
    bit       to;
    int       polls;
  } exp_t;
  exp_t sb_q[$];

  task automatic run_op(input bit w, input bit [6:0] a, input bit [7:0] d, input int bz);
    exp_t e;
    while (!ready) @(negedge clk);
    busy_cfg = bz;
    log_idx  = 0;
    e.wr = w; e.a = a; e.to = 0; e.polls = 0;
    if (w) begin
      shadow[a] = d;
      e.d = d;
      e.polls = (bz < 1) ? 1 : bz;
      if (e.polls > LIMIT) begin e.polls = LIMIT; e.to = 1; end
    end else e.d = shadow[a];
    sb_q.push_back(e);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) chk(0, "R7", "done without accepted request", 1, 0);
        else begin
          e = sb_q.pop_front();
          chk(timeout == e.to, e.to ? "R4" : "R8", "timeout flag", timeout, e.to);
          if (!e.wr) begin
            chk(rdata == e.d, "R1", "read data", rdata, e.d);
            chk(log_idx == 1, "R1", "read transactions", log_idx, 1);
            chk(m_logw[0] == {3'b110, e.a}, "R1", "read command", m_logw[0], {3'b110, e.a});
            chk(m_logb[0] == 18, "R1", "read pulses", m_logb[0], 18);
          end else begin
            chk(log_idx == 4, "R2", "write transactions", log_idx, 4);
            chk(m_logw[0] == 10'h260 && m_logb[0] == 10, "R2", "unlock word", m_logw[0], 10'h260);
            chk(m_logw[1] == {3'b101, e.a} && m_logb[1] == 18, "R2", "write frame",
                m_logw[1], {3'b101, e.a});
            chk(m_logb[2] == e.polls, e.to ? "R4" : "R3", "poll pulses", m_logb[2], e.polls);
            chk(m_logw[3] == 10'h200 && m_logb[3] == 10, e.to ? "R4" : "R2", "lock word",
                m_logw[3], 10'h200);
            chk(m_wen == 0, "R2", "memory left locked", m_wen, 0);
            chk(m_mem[e.a] == e.d, "R2", "byte stored", m_mem[e.a], e.d);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 128; i++) begin
      m_mem[i]  = 8'(i * 29 + 7);
      shadow[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!cs && !sclk && !sdo, "R9", "serial pins low", {cs, sclk, sdo}, 0);
    chk(ready && !busy, "R9", "ready/busy", {ready, busy}, 2);
    chk(!done && !timeout, "R9", "done/timeout", {done, timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && !busy && !cs, "R9", "idle after release", {ready, busy, cs}, 4);

    run_op(1, 7'h05, 8'hA5, 3);
    run_op(0, 7'h05, 8'h00, 0);
    run_op(0, 7'h7F, 8'h00, 0);          // top address, initial content
    run_op(1, 7'h7F, 8'h00, 0);          // ready on first poll pulse
    run_op(0, 7'h7F, 8'h00, 0);
    run_op(1, 7'h00, 8'hFF, LIMIT);      // ready exactly on the last allowed pulse
    run_op(0, 7'h00, 8'h00, 0);
    run_op(1, 7'h2A, 8'h3C, LIMIT + 1);  // R4 timeout
    run_op(0, 7'h2A, 8'h00, 0);          // R8 timeout cleared on next request

    // R7: request during a write is ignored
    fork
      run_op(1, 7'h11, 8'h5A, 2);
      begin
        repeat (40) @(negedge clk);
        chk(!ready && busy, "R7", "ready low while busy", ready, 0);
        req = 1'b1; wr = 1'b0; addr = 7'h33;
        @(negedge clk);
        req = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk(ready && !busy && !done, "R7", "idle after ignored request", {ready, busy, done}, 4);
    run_op(0, 7'h11, 8'h00, 0);

    chk(hi_min == HIGH && hi_max == HIGH, "R5", "clock high width", hi_max, HIGH);
    chk(setup_min >= SETUP, "R5", "data setup before rise", setup_min, SETUP);
    chk(csfirst_min >= CSU + SETUP, "R6", "select to first rise", csfirst_min, CSU + SETUP);
    chk(sb_q.size() == 0, "R8", "pending expectations", sb_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule